// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM

A single-port synchronous SRAM in which a write's data follows its command by the same number of cycles as a read's data does. Because of this, read and write commands can be issued on consecutive clocks in any mix, and the shared data bus never needs an idle turnaround cycle. Each command is taken at a rising clock edge from a chip select, a load/continue strobe, a write strobe and a set of per-lane write selects. A continue cycle repeats the previous operation type at an address produced by a small internal counter, which wraps inside a group of four words.

The data bus is split into lanes of `LW` bits. Each lane holds eight data bits and one parity bit. The bus is presented as the pad signals of a bidirectional pin: the value coming in, the value going out, and a drive enable. The output enable acts combinationally on the drive enable and never forces a drive while a write data cycle is in progress. When the clock-enable input is high, or the sleep input is high, the clock edge is ignored and all state is frozen.

Top module: `pipe_sram`

## Requirements
- R1: While `rst_ni` is low, and at the first sample after it rises, `dq_oe_o` is low whatever `oe_n_i` is.
- R2: An enabled edge with `ce_n_i` high and `adv_ld_i` low is a deselect. A later `adv_ld_i` high edge continues the deselect. In both cases `dq_oe_o` stays low in the data cycle.
- R3: A read (`ce_n_i` low, `adv_ld_i` low, `we_n_i` high) taken at enabled edge k drives the word at `addr_i` on `dq_o`, with `dq_oe_o` high, from enabled edge k+1 until the next enabled edge, provided `oe_n_i` is low.
- R4: A write (`we_n_i` low) taken at enabled edge k stores `dq_i` at enabled edge k+2. Lane j is bits [9j+8:9j], and it is updated only where `bw_n_i[j]` sampled with the command is low.
- R5: A write whose `bw_n_i` bits are all high leaves the memory unchanged.
- R6: In the data cycle of any write, including a partial or aborted write, `dq_oe_o` is low whatever `oe_n_i` is.
- R7: `oe_n_i` high forces `dq_oe_o` low in the same cycle, without waiting for a clock edge.
- R8: An enabled edge with `adv_ld_i` high repeats the previous operation type at the previous address, with bits [1:0] incremented modulo 4 and the upper bits kept. `ce_n_i` and `we_n_i` are ignored on such an edge, and `bw_n_i` is taken fresh each cycle.
- R9: An edge with `cen_n_i` high is ignored. The pipeline, the burst address and `dq_o` all hold.
- R10: While `zz_i` is high, clock edges are ignored and `dq_oe_o` is low. When `zz_i` falls, the pipeline resumes from where it stopped.
- R11: A read taken one edge after a write to the same address returns the newly written lanes merged with the old content of the unselected lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_n_i | input | 1 | Clock enable, active low; high stalls |
| zz_i | input | 1 | Sleep; high ignores edges and floats bus |
| ce_n_i | input | 1 | Chip select, active low |
| adv_ld_i | input | 1 | Low loads a new address, high continues |
| we_n_i | input | 1 | Write strobe, active low |
| bw_n_i | input | NB | Per-lane write selects, active low |
| addr_i | input | AW | Word address |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_i | input | NB*LW | Bus value seen at the pad |
| dq_o | output | NB*LW | Bus value to drive |
| dq_oe_o | output | 1 | Pad drive enable |

## Verification
The hardest case to reach is a read that lands exactly one edge behind a partial write to the same word. In that case the memory has not yet been written, and the read has to merge the lanes that are still on the bus. A directed sequence sets this up, and a long random phase keeps addresses within sixteen words, so that reads and writes to the same address, stalls and sleep cycles fall inside the two-edge window very often. A second hard case is a continue burst that crosses a four-word wrap while `ce_n_i` and `we_n_i` carry conflicting values. A directed burst that starts at the third word of a group reaches it.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/pipe_sram_array.sv
module pipe_sram_array #(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int LW = 9
) (
  input  logic                 clk_i,
  input  logic [AW-1:0]        rd_addr_i,
  output logic [NB*LW-1:0]     rd_data_o,
  input  logic                 wr_en_i,
  input  logic [AW-1:0]        wr_addr_i,
  input  logic [NB-1:0]        wr_be_i,
  input  logic [NB*LW-1:0]     wr_data_i
);
  localparam int DEPTH = 1 << AW;
  localparam int DW    = NB * LW;

  logic [DW-1:0] mem_q [DEPTH];

  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int j = 0; j < NB; j++) begin
        if (wr_be_i[j]) mem_q[wr_addr_i][j*LW +: LW] <= wr_data_i[j*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/pipe_sram_decode.sv
module pipe_sram_decode
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           ce_n_i,
  input  logic           adv_ld_i,
  input  logic           we_n_i,
  input  logic [NB-1:0]  bw_n_i,
  input  logic [AW-1:0]  addr_i,
  output op_e            cmd_op_o,
  output logic [AW-1:0]  cmd_addr_o,
  output logic [NB-1:0]  cmd_be_o
);
  op_e           bst_op_q;
  logic [AW-1:0] bst_addr_q;
  logic [AW-1:0] bst_next;

  // linear wrap inside a 4-word group
  assign bst_next = {bst_addr_q[AW-1:2], bst_addr_q[1:0] + 2'd1};

  always_comb begin
    if (!adv_ld_i) begin
      cmd_addr_o = addr_i;
      if (ce_n_i)      cmd_op_o = OP_IDLE;
      else if (we_n_i) cmd_op_o = OP_RD;
      else             cmd_op_o = OP_WR;
    end else begin
      cmd_addr_o = bst_next;
      cmd_op_o   = bst_op_q;
    end
    cmd_be_o = (cmd_op_o == OP_WR) ? ~bw_n_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bst_op_q   <= OP_IDLE;
      bst_addr_q <= '0;
    end else if (en_i) begin
      bst_op_q   <= cmd_op_o;
      bst_addr_q <= cmd_addr_o;
    end
  end
endmodule

// File: rtl/pipe_sram_pipe.sv
module pipe_sram_pipe
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int LW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  op_e               cmd_op_i,
  input  logic [AW-1:0]     cmd_addr_i,
  input  logic [NB-1:0]     cmd_be_i,
  input  logic [NB*LW-1:0]  dq_i,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [NB*LW-1:0]  rd_data_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [NB-1:0]     wr_be_o,
  output logic [NB*LW-1:0]  wr_data_o,
  output logic [NB*LW-1:0]  dout_o,
  output logic              drive_o,
  output op_e               s1_op_o,
  output logic [AW-1:0]     s1_addr_o,
  output op_e               s2_op_o
);
  localparam int DW = NB * LW;

  op_e           s1_op_q,   s2_op_q;
  logic [AW-1:0] s1_addr_q, s2_addr_q;
  logic [NB-1:0] s1_be_q,   s2_be_q;
  logic [DW-1:0] dout_q;
  logic [DW-1:0] rd_merged;
  logic          hit;

  assign hit = (s2_op_q == OP_WR) && (s2_addr_q == s1_addr_q);

  // forward lanes of the write being captured this edge
  for (genvar j = 0; j < NB; j++) begin : g_lane
    assign rd_merged[j*LW +: LW] = (hit && s2_be_q[j]) ? dq_i[j*LW +: LW]
                                                       : rd_data_i[j*LW +: LW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_q   <= OP_IDLE;
      s2_op_q   <= OP_IDLE;
      s1_addr_q <= '0;
      s2_addr_q <= '0;
      s1_be_q   <= '0;
      s2_be_q   <= '0;
      dout_q    <= '0;
    end else if (en_i) begin
      s1_op_q   <= cmd_op_i;
      s1_addr_q <= cmd_addr_i;
      s1_be_q   <= cmd_be_i;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
      if (s1_op_q == OP_RD) dout_q <= rd_merged;
    end
  end

  assign rd_addr_o = s1_addr_q;
  assign wr_en_o   = en_i && (s2_op_q == OP_WR) && (|s2_be_q);
  assign wr_addr_o = s2_addr_q;
  assign wr_be_o   = s2_be_q;
  assign wr_data_o = dq_i;
  assign dout_o    = dout_q;
  assign drive_o   = (s2_op_q == OP_RD);
  assign s1_op_o   = s1_op_q;
  assign s1_addr_o = s1_addr_q;
  assign s2_op_o   = s2_op_q;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int LW = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_n_i,
  input  logic              zz_i,
  input  logic              ce_n_i,
  input  logic              adv_ld_i,
  input  logic              we_n_i,
  input  logic [NB-1:0]     bw_n_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              oe_n_i,
  input  logic [NB*LW-1:0]  dq_i,
  output logic [NB*LW-1:0]  dq_o,
  output logic              dq_oe_o
);
  localparam int DW = NB * LW;

  logic          en;
  op_e           cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [NB-1:0] cmd_be;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [NB-1:0] wr_be;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] dout;
  logic          drive;
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  op_e           s2_op;

  assign en = !cen_n_i && !zz_i;

  pipe_sram_decode #(.AW(AW), .NB(NB)) i_decode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .ce_n_i     (ce_n_i),
    .adv_ld_i   (adv_ld_i),
    .we_n_i     (we_n_i),
    .bw_n_i     (bw_n_i),
    .addr_i     (addr_i),
    .cmd_op_o   (cmd_op),
    .cmd_addr_o (cmd_addr),
    .cmd_be_o   (cmd_be)
  );

  pipe_sram_pipe #(.AW(AW), .NB(NB), .LW(LW)) i_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .cmd_op_i   (cmd_op),
    .cmd_addr_i (cmd_addr),
    .cmd_be_i   (cmd_be),
    .dq_i       (dq_i),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_be_o    (wr_be),
    .wr_data_o  (wr_data),
    .dout_o     (dout),
    .drive_o    (drive),
    .s1_op_o    (s1_op),
    .s1_addr_o  (s1_addr),
    .s2_op_o    (s2_op)
  );

  pipe_sram_array #(.AW(AW), .NB(NB), .LW(LW)) i_array (
    .clk_i     (clk_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_be_i   (wr_be),
    .wr_data_i (wr_data)
  );

  // output enable is asynchronous; sleep floats the bus
  assign dq_oe_o = drive && !oe_n_i && !zz_i;
  assign dq_o    = dout;
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int NB = 2,
  parameter int LW = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cen_n_i,
  input logic              zz_i,
  input logic              ce_n_i,
  input logic              adv_ld_i,
  input logic              oe_n_i,
  input logic [NB*LW-1:0]  dq_o,
  input logic              dq_oe_o,
  input op_e               s1_op,
  input logic [AW-1:0]     s1_addr,
  input op_e               s2_op
);
  // R1
  always_comb begin
    if (!rst_ni) rst_hiz_chk: assert (!dq_oe_o);
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen_n_i || zz_i) |=> ($stable(dq_o) && $stable(s2_op) && $stable(s1_addr)));

  // R10
  sleep_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zz_i |-> !dq_oe_o);

  // R6
  wr_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s2_op == OP_WR) |-> !dq_oe_o);

  // R3
  drv_rd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> ((s2_op == OP_RD) && !oe_n_i));

  // R8
  burst_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_i && !zz_i && adv_ld_i) |=>
      ((s1_addr[AW-1:2] == $past(s1_addr[AW-1:2])) &&
       (s1_addr[1:0] == $past(s1_addr[1:0]) + 2'd1)));

  // R2
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_i && !zz_i && ce_n_i && !adv_ld_i) |=> (s1_op == OP_IDLE));
endmodule

bind pipe_sram pipe_sram_chk #(.AW(AW), .NB(NB), .LW(LW)) i_chk (.*);

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
  localparam int AW = 6;
  localparam int NB = 2;
  localparam int LW = 9;
  localparam int DW = NB * LW;
  localparam int DEPTH = 1 << AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cen_n_i = 1'b0, zz_i = 1'b0, ce_n_i = 1'b1, adv_ld_i = 1'b0, we_n_i = 1'b1;
  logic [NB-1:0] bw_n_i = '1;
  logic [AW-1:0] addr_i = '0;
  logic oe_n_i = 1'b0;
  logic [DW-1:0] dq_i = '0;
  logic [DW-1:0] dq_o;
  logic dq_oe_o;

  always #5 clk_i = ~clk_i;

  pipe_sram #(.AW(AW), .NB(NB), .LW(LW)) i_pipe_sram (
    .clk_i(clk_i), .rst_ni(rst_ni), .cen_n_i(cen_n_i), .zz_i(zz_i),
    .ce_n_i(ce_n_i), .adv_ld_i(adv_ld_i), .we_n_i(we_n_i), .bw_n_i(bw_n_i),
    .addr_i(addr_i), .oe_n_i(oe_n_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe_o(dq_oe_o)
  );

  int total = 0;
  int bad = 0;

  // reference model: op 0 idle, 1 read, 2 write
  int m_op1 = 0, m_op2 = 0, m_bop = 0;
  logic [AW-1:0] m_a1 = '0, m_a2 = '0, m_ba = '0;
  logic [NB-1:0] m_be1 = '0, m_be2 = '0;
  logic [DW-1:0] m_dout = '0;
  string m_tag1 = "R3", m_dtag = "R3";
  logic [DW-1:0] ref_mem [DEPTH];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    int op;
    logic [AW-1:0] a;
    if (cen_n_i || zz_i) return;
    if (m_op1 == 1) m_dtag = (m_op2 == 2 && m_a2 == m_a1 && |m_be2) ? "R11" : m_tag1;
    if (m_op2 == 2)
      for (int j = 0; j < NB; j++)
        if (m_be2[j]) ref_mem[m_a2][j*LW +: LW] = dq_i[j*LW +: LW];
    if (m_op1 == 1) m_dout = ref_mem[m_a1];
    m_op2 = m_op1; m_a2 = m_a1; m_be2 = m_be1;
    if (!adv_ld_i) begin
      a = addr_i;
      op = ce_n_i ? 0 : (we_n_i ? 1 : 2);
      m_tag1 = "R3";
    end else begin
      a = {m_ba[AW-1:2], m_ba[1:0] + 2'd1};
      op = m_bop;
      m_tag1 = "R8";
    end
    m_op1 = op; m_a1 = a; m_be1 = (op == 2) ? ~bw_n_i : '0;
    m_bop = op; m_ba = a;
  endtask

  task automatic sample();
    logic exp_oe;
    string tag;
    exp_oe = (m_op2 == 1) && !oe_n_i && !zz_i;
    if (m_op2 == 2)     tag = "R6";
    else if (zz_i)      tag = "R10";
    else if (oe_n_i)    tag = "R7";
    else if (m_op2 == 0) tag = "R2";
    else                tag = "R3";
    chk(dq_oe_o == exp_oe, tag, DW'(dq_oe_o), DW'(exp_oe));
    if (exp_oe) chk(dq_o == m_dout, m_dtag, dq_o, m_dout);
  endtask

  task automatic step(input logic ce, input logic adv, input logic we, input logic [NB-1:0] bw,
                      input logic [AW-1:0] a, input logic cen, input logic zz, input logic oe,
                      input logic [DW-1:0] d);
    ce_n_i = ce; adv_ld_i = adv; we_n_i = we; bw_n_i = bw; addr_i = a;
    cen_n_i = cen; zz_i = zz; oe_n_i = oe; dq_i = d;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    sample();
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b0, 1'b0, 1'b1, '1, a, 1'b0, 1'b0, 1'b0, DW'($urandom));
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [NB-1:0] bw, input logic [DW-1:0] d);
    step(1'b0, 1'b0, 1'b0, bw, a, 1'b0, 1'b0, 1'b0, d);
  endtask
  task automatic nop(input logic [DW-1:0] d);
    step(1'b1, 1'b0, 1'b1, '1, '0, 1'b0, 1'b0, 1'b0, d);
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v1, v2, v3, v4, held;
    void'($urandom(32'd7091));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1: no drive during reset with oe low
    chk(dq_oe_o == 1'b0, "R1", DW'(dq_oe_o), '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(dq_oe_o == 1'b0, "R1", DW'(dq_oe_o), '0);

    // fill words 0..15
    for (int a = 0; a < 16; a++) wr(AW'(a), '0, DW'($urandom));
    nop(DW'($urandom)); nop(DW'($urandom));

    // R4 / R5: full, partial, abort to word 2
    v1 = 18'h2A5C3; v2 = 18'h15A3C; v3 = 18'h3FFFF;
    wr(6'd2, 2'b00, DW'($urandom));
    wr(6'd2, 2'b10, DW'($urandom));
    wr(6'd2, 2'b11, v1);
    nop(v2);
    nop(v3);
    rd(6'd2);
    nop(DW'($urandom));
    chk(dq_o == {v1[17:9], v2[8:0]}, "R4", dq_o, {v1[17:9], v2[8:0]});
    chk(dq_o[8:0] == v2[8:0], "R5", dq_o, {v1[17:9], v2[8:0]});

    // R11: read right behind a partial write to the same word
    held = ref_mem[5];
    v4 = 18'h0F0F1;
    wr(6'd5, 2'b01, DW'($urandom));
    rd(6'd5);
    nop(v4);
    chk(dq_o == {v4[17:9], held[8:0]}, "R11", dq_o, {v4[17:9], held[8:0]});
    nop(DW'($urandom));

    // R8: burst from word 6 wraps 6,7,4,5; ce/we ignored on continue
    rd(6'd6);
    step(1'b1, 1'b1, 1'b0, 2'b00, 6'd33, 1'b0, 1'b0, 1'b0, DW'($urandom));
    chk(dq_o == ref_mem[6] && dq_oe_o, "R8", dq_o, ref_mem[6]);
    step(1'b1, 1'b1, 1'b0, 2'b00, 6'd33, 1'b0, 1'b0, 1'b0, DW'($urandom));
    chk(dq_o == ref_mem[7] && dq_oe_o, "R8", dq_o, ref_mem[7]);
    step(1'b0, 1'b1, 1'b0, 2'b00, 6'd33, 1'b0, 1'b0, 1'b0, DW'($urandom));
    chk(dq_o == ref_mem[4] && dq_oe_o, "R8", dq_o, ref_mem[4]);
    nop(DW'($urandom));
    chk(dq_o == ref_mem[5] && dq_oe_o, "R8", dq_o, ref_mem[5]);
    nop(DW'($urandom));

    // R2: deselect then continue deselect
    step(1'b1, 1'b0, 1'b1, '1, 6'd1, 1'b0, 1'b0, 1'b0, DW'($urandom));
    step(1'b0, 1'b1, 1'b1, '1, 6'd1, 1'b0, 1'b0, 1'b0, DW'($urandom));
    step(1'b0, 1'b1, 1'b1, '1, 6'd1, 1'b0, 1'b0, 1'b0, DW'($urandom));
    chk(dq_oe_o == 1'b0, "R2", DW'(dq_oe_o), '0);
    nop(DW'($urandom));
    chk(dq_oe_o == 1'b0, "R2", DW'(dq_oe_o), '0);

    // R9: stall holds read data
    rd(6'd9);
    nop(DW'($urandom));
    held = ref_mem[9];
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 1'b0, 2'b00, 6'd9, 1'b1, 1'b0, 1'b0, DW'($urandom));
      chk(dq_o == held && dq_oe_o, "R9", dq_o, held);
    end
    nop(DW'($urandom));

    // R10: sleep floats bus, then resumes
    rd(6'd10);
    nop(DW'($urandom));
    held = ref_mem[10];
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b0, 1'b0, 2'b00, 6'd10, 1'b0, 1'b1, 1'b0, DW'($urandom));
      chk(dq_oe_o == 1'b0, "R10", DW'(dq_oe_o), '0);
    end
    zz_i = 1'b0;
    #1;
    chk(dq_o == held && dq_oe_o, "R10", dq_o, held);
    nop(DW'($urandom));

    // R7: asynchronous output enable
    rd(6'd11);
    nop(DW'($urandom));
    oe_n_i = 1'b1;
    #1;
    chk(dq_oe_o == 1'b0, "R7", DW'(dq_oe_o), '0);
    oe_n_i = 1'b0;
    #1;
    chk(dq_oe_o == 1'b1, "R7", DW'(dq_oe_o), '1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 6) == 0, ($urandom % 3) == 0, 1'($urandom), NB'($urandom),
           AW'($urandom % 16), ($urandom % 10) == 0, ($urandom % 25) == 0,
           ($urandom % 8) == 0, DW'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule